// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the fetch program counter. It holds a small direct-mapped table of branches that have been seen taken. Each row records whether it is in use, the complete address of the branch it describes, the address that branch jumped to, and a two-bit confidence counter. The lookup uses only combinational logic: in the cycle the fetch address is presented, the block says whether the row matches and supplies the next fetch address. The predicted target is used when the row matches and its counter leans toward taken. In every other case the next address is the sequential one, four bytes on.

A single write channel trains the table when a branch resolves later in the pipeline. A resolved branch that matches its row moves the counter one step toward its outcome. A taken outcome also refreshes the stored target. A taken branch that finds no matching row claims the row, and any branch that held it is lost. The row records the whole branch address, so two branches that share a row can never borrow each other's target.

Top module: `btb_predictor`

## Requirements
- R1: After reset every row is unused: no fetch address hits, `pred_hit` and `pred_taken` are 0, and `pred_next_pc` equals `fetch_pc` + 4.
- R2: The row is selected by address bits [IDX_W+1:2] (IDX_W = log2 ENTRIES; bits [5:2] by default). A hit requires all other address bits, including bits [1:0] and the upper bits, to equal the stored branch address. An address that shares a row but differs elsewhere (for example, the default build with an offset of 0x40, or a different bit 31) misses.
- R3: On a miss, `pred_hit` = 0, `pred_taken` = 0 and `pred_next_pc` = `fetch_pc` + 4.
- R4: On a hit whose counter is 2 or 3, `pred_taken` = 1 and `pred_next_pc` is the stored target, both in the same cycle as `fetch_pc`.
- R5: On a hit whose counter is 0 or 1, `pred_hit` = 1, `pred_taken` = 0 and `pred_next_pc` = `fetch_pc` + 4.
- R6: A taken resolve (`upd_valid`=1, `upd_taken`=1) whose address misses claims its row. The row then holds that address, `upd_target` and counter value 2, and the previous occupant stops hitting.
- R7: A not-taken resolve whose address misses changes nothing.
- R8: A resolve whose address hits trains the row. A taken outcome adds 1 to the counter, saturating at 3, and stores `upd_target`. A not-taken outcome subtracts 1, saturating at 0, and keeps the stored target.
- R9: A write takes effect at the clock edge. A lookup of the row being written in that same cycle sees the row's old contents, and the new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all row valid flags |
| fetch_pc | input | ADDR_W | Fetch address being looked up |
| pred_hit | output | 1 | Row is in use and its stored branch address equals `fetch_pc` |
| pred_taken | output | 1 | Hit with counter at 2 or above |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The lookup and the training write can fall in the same cycle on the same row. The bench provokes this by driving a fresh taken branch on the write channel while `fetch_pc` carries the same address. It expects a miss in that cycle and a hit on the new target in the following cycle. The checker covers the same boundary: in the cycle after a taken write, a still-held matching `fetch_pc` must hit, and after a not-taken write to an address that missed, it must still miss.

// File: rtl/btb_pkg.sv
package btb_pkg;

   // Kind of write the training logic issues to the entry array
   typedef enum logic [1:0] {
      BTB_OP_NONE  = 2'd0,
      BTB_OP_ALLOC = 2'd1,
      BTB_OP_TRAIN = 2'd2
   } btb_op_e;

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = ADDR_W - IDX_W
) (
   input  logic [ADDR_W-1:0] pc,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);

   // Row select sits just above the byte offset; everything else is kept as tag
   assign idx = pc[IDX_W+1:2];
   assign tag = {pc[ADDR_W-1:IDX_W+2], pc[1:0]};

endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
   import btb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 2,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int TAG_W   = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   // lookup read port
   input  logic [IDX_W-1:0]  la_idx,
   output logic              la_valid,
   output logic [TAG_W-1:0]  la_tag,
   output logic [ADDR_W-1:0] la_target,
   output logic [CNT_W-1:0]  la_cnt,
   // training read port
   input  logic [IDX_W-1:0]  tr_idx,
   output logic              tr_valid,
   output logic [TAG_W-1:0]  tr_tag,
   output logic [ADDR_W-1:0] tr_target,
   output logic [CNT_W-1:0]  tr_cnt,
   // write port
   input  btb_op_e           wr_op,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ADDR_W-1:0] wr_target,
   input  logic [CNT_W-1:0]  wr_cnt
);

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q    [ENTRIES];
   logic [ADDR_W-1:0]  target_q [ENTRIES];
   logic [CNT_W-1:0]   cnt_q    [ENTRIES];
   logic [ENTRIES-1:0] wsel;

   // One-hot row write enables
   for (genvar e = 0; e < ENTRIES; e++) begin : g_wsel
      assign wsel[e] = (wr_op != BTB_OP_NONE) && (wr_idx == IDX_W'(e));
   end

   // Only the valid flags need reset; payload is qualified by them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (wsel[e]) valid_q[e] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
         if (wsel[e]) begin
            tag_q[e]    <= wr_tag;
            target_q[e] <= wr_target;
            cnt_q[e]    <= wr_cnt;
         end
      end
   end

   assign la_valid  = valid_q[la_idx];
   assign la_tag    = tag_q[la_idx];
   assign la_target = target_q[la_idx];
   assign la_cnt    = cnt_q[la_idx];

   assign tr_valid  = valid_q[tr_idx];
   assign tr_tag    = tag_q[tr_idx];
   assign tr_target = target_q[tr_idx];
   assign tr_cnt    = cnt_q[tr_idx];

endmodule

// File: rtl/btb_train.sv
module btb_train
   import btb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 2,
   parameter int TAG_W  = 28
) (
   input  logic              upd_valid,
   input  logic              upd_taken,
   input  logic [TAG_W-1:0]  upd_tag,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic              row_valid,
   input  logic [TAG_W-1:0]  row_tag,
   input  logic [ADDR_W-1:0] row_target,
   input  logic [CNT_W-1:0]  row_cnt,
   output btb_op_e           wr_op,
   output logic [ADDR_W-1:0] wr_target,
   output logic [CNT_W-1:0]  wr_cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_WEAK = CNT_W'(1) << (CNT_W - 1);

   logic row_match;
   assign row_match = row_valid && (row_tag == upd_tag);

   always_comb begin
      wr_op     = BTB_OP_NONE;
      wr_target = row_target;
      wr_cnt    = row_cnt;
      if (upd_valid && row_match) begin
         wr_op = BTB_OP_TRAIN;
         if (upd_taken) begin
            wr_cnt    = (row_cnt == CNT_MAX) ? row_cnt : row_cnt + CNT_W'(1);
            wr_target = upd_target;
         end else begin
            wr_cnt    = (row_cnt == '0) ? row_cnt : row_cnt - CNT_W'(1);
         end
      end else if (upd_valid && upd_taken) begin
         wr_op     = BTB_OP_ALLOC;
         wr_cnt    = CNT_WEAK;
         wr_target = upd_target;
      end
   end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 2,
   parameter int TAG_W  = 28
) (
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic [TAG_W-1:0]  fetch_tag,
   input  logic              row_valid,
   input  logic [TAG_W-1:0]  row_tag,
   input  logic [ADDR_W-1:0] row_target,
   input  logic [CNT_W-1:0]  row_cnt,
   output logic              hit,
   output logic              taken,
   output logic [ADDR_W-1:0] next_pc
);

   // Upper half of the counter range means taken
   assign hit     = row_valid && (row_tag == fetch_tag);
   assign taken   = hit && row_cnt[CNT_W-1];
   assign next_pc = taken ? row_target : fetch_pc + ADDR_W'(4);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
   import btb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic              pred_hit,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_next_pc,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target
);

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("btb_predictor: ENTRIES must be a power of two, at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("btb_predictor: CNT_W must be at least 1");
   end
   if (ADDR_W < IDX_W + 3) begin : g_bad_addr
      $error("btb_predictor: ADDR_W too small for ENTRIES");
   end

   logic [IDX_W-1:0]  f_idx, u_idx;
   logic [TAG_W-1:0]  f_tag, u_tag;
   logic              la_valid, tr_valid;
   logic [TAG_W-1:0]  la_tag, tr_tag;
   logic [ADDR_W-1:0] la_target, tr_target;
   logic [CNT_W-1:0]  la_cnt, tr_cnt;
   btb_op_e           wr_op;
   logic [ADDR_W-1:0] wr_target;
   logic [CNT_W-1:0]  wr_cnt;

   btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_fetch (
      .pc(fetch_pc), .idx(f_idx), .tag(f_tag));

   btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_upd (
      .pc(upd_pc), .idx(u_idx), .tag(u_tag));

   btb_entry_array #(
      .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .la_idx(f_idx), .la_valid(la_valid), .la_tag(la_tag),
      .la_target(la_target), .la_cnt(la_cnt),
      .tr_idx(u_idx), .tr_valid(tr_valid), .tr_tag(tr_tag),
      .tr_target(tr_target), .tr_cnt(tr_cnt),
      .wr_op(wr_op), .wr_idx(u_idx), .wr_tag(u_tag),
      .wr_target(wr_target), .wr_cnt(wr_cnt));

   btb_train #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_train (
      .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_tag(u_tag),
      .upd_target(upd_target),
      .row_valid(tr_valid), .row_tag(tr_tag), .row_target(tr_target), .row_cnt(tr_cnt),
      .wr_op(wr_op), .wr_target(wr_target), .wr_cnt(wr_cnt));

   btb_lookup #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_lookup (
      .fetch_pc(fetch_pc), .fetch_tag(f_tag),
      .row_valid(la_valid), .row_tag(la_tag), .row_target(la_target), .row_cnt(la_cnt),
      .hit(pred_hit), .taken(pred_taken), .next_pc(pred_next_pc));

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic              pred_hit,
   input logic              pred_taken,
   input logic [ADDR_W-1:0] pred_next_pc,
   input logic              upd_valid,
   input logic [ADDR_W-1:0] upd_pc,
   input logic              upd_taken,
   input logic [ADDR_W-1:0] upd_target
);

   // R1: first sampled cycle out of reset has no hit
   a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pred_hit);

   // R3, R5: whenever not predicting taken, the sequential address is offered
   a_r3_seq_when_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (pred_next_pc == fetch_pc + ADDR_W'(4)));

   // R4, R5: a taken prediction only comes from a matching row
   a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> pred_hit);

   // R6, R9: after a taken write, the same held fetch address hits
   a_r6_taken_write_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && fetch_pc == upd_pc)
      |=> ((fetch_pc != $past(fetch_pc)) || pred_hit));

   // R7: a not-taken write on a missing address leaves it missing
   a_r7_not_taken_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && fetch_pc == upd_pc && !pred_hit)
      |=> ((fetch_pc != $past(fetch_pc)) || !pred_hit));

   // Unused here beyond the port list
   logic unused_ok;
   assign unused_ok = ^upd_target;

endmodule

bind btb_predictor btb_checker #(.ADDR_W(ADDR_W)) u_btb_checker (
   .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
   .pred_taken(pred_taken), .pred_next_pc(pred_next_pc), .upd_valid(upd_valid),
   .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target));

// File: tb/btb_predictor_test.sv
module btb_predictor_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic          pred_hit, pred_taken;
   logic [AW-1:0] pred_next_pc;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_pc = '0;
   logic          upd_taken = 1'b0;
   logic [AW-1:0] upd_target = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   btb_predictor #(.ENTRIES(16), .ADDR_W(AW), .CNT_W(2)) uut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
      .pred_taken(pred_taken), .pred_next_pc(pred_next_pc), .upd_valid(upd_valid),
      .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target));

   task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                      input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Present a fetch address and check the combinational prediction
   task automatic look(input string req, input logic [AW-1:0] pc, input logic hit,
                       input logic tkn, input logic [AW-1:0] nxt);
      @(negedge clk);
      fetch_pc = pc;
      #1;
      chk(req, "hit", AW'(pred_hit), AW'(hit));
      chk(req, "taken", AW'(pred_taken), AW'(tkn));
      chk(req, "next", pred_next_pc, nxt);
   endtask

   // One resolved branch, captured at the next rising edge
   task automatic resolve(input logic [AW-1:0] pc, input logic tkn, input logic [AW-1:0] tgt);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tkn; upd_target = tgt;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic t_reset;
      look("R1", 32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104);
      look("R1", 32'h0000_0308, 1'b0, 1'b0, 32'h0000_030C);
   endtask

   task automatic t_alloc;
      resolve(32'h0000_0100, 1'b1, 32'h0000_0800);
      look("R6_R4", 32'h0000_0100, 1'b1, 1'b1, 32'h0000_0800);
      look("R3", 32'h0000_0104, 1'b0, 1'b0, 32'h0000_0108);
   endtask

   task automatic t_not_taken_miss;
      resolve(32'h0000_0204, 1'b0, 32'h0000_0900);
      look("R7", 32'h0000_0204, 1'b0, 1'b0, 32'h0000_0208);
   endtask

   task automatic t_alias;
      // same row as 0x100 (bits [5:2] zero), different upper bits
      look("R2", 32'h0000_0140, 1'b0, 1'b0, 32'h0000_0144);
      look("R2", 32'h8000_0100, 1'b0, 1'b0, 32'h8000_0104);
      look("R2", 32'h0000_0101, 1'b0, 1'b0, 32'h0000_0105);
      resolve(32'h0000_0140, 1'b1, 32'h0000_0A00);
      look("R6", 32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104);
      look("R6", 32'h0000_0140, 1'b1, 1'b1, 32'h0000_0A00);
   endtask

   task automatic t_counter;
      // row for 0x140 holds counter 2, target 0xA00
      resolve(32'h0000_0140, 1'b1, 32'h0000_0A00);   // 3
      resolve(32'h0000_0140, 1'b1, 32'h0000_0A00);   // stays 3
      resolve(32'h0000_0140, 1'b0, 32'h0000_DEAD);   // 2, target kept
      look("R8", 32'h0000_0140, 1'b1, 1'b1, 32'h0000_0A00);
      resolve(32'h0000_0140, 1'b0, 32'h0000_DEAD);   // 1
      look("R5", 32'h0000_0140, 1'b1, 1'b0, 32'h0000_0144);
      resolve(32'h0000_0140, 1'b0, 32'h0000_DEAD);   // 0
      resolve(32'h0000_0140, 1'b0, 32'h0000_DEAD);   // stays 0
      resolve(32'h0000_0140, 1'b1, 32'h0000_0B00);   // 1
      look("R8", 32'h0000_0140, 1'b1, 1'b0, 32'h0000_0144);
      resolve(32'h0000_0140, 1'b1, 32'h0000_0C00);   // 2, new target
      look("R8", 32'h0000_0140, 1'b1, 1'b1, 32'h0000_0C00);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      fetch_pc = 32'h0000_0308;
      upd_valid = 1'b1; upd_pc = 32'h0000_0308; upd_taken = 1'b1; upd_target = 32'h0000_0E00;
      #1;
      chk("R9", "old hit", AW'(pred_hit), AW'(1'b0));
      chk("R9", "old next", pred_next_pc, 32'h0000_030C);
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      chk("R9", "new hit", AW'(pred_hit), AW'(1'b1));
      chk("R9", "new next", pred_next_pc, 32'h0000_0E00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_alloc();
      t_not_taken_miss();
      t_alias();
      t_counter();
      t_same_cycle();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule